// File: doc/BRIEF.md
# Cache-Line Fetch Group Extractor

This block sits between an instruction cache and a decode stage. Each cycle it takes the cache line that holds the current fetch address. It cuts out consecutive 32-bit instruction words, starting at that address, and presents them as a numbered group to decode. Each emitted instruction carries:

- its own address,
- a sequence number drawn from a running counter,
- the address that is predicted to follow it.

A single bit of the instruction word marks an instruction as control flow. For control instructions the block asks an external branch predictor, through one combinational query lane per slot, whether the branch is taken and where it goes. The group ends at the first of three events:

- the line runs out,
- the fetch width is reached,
- a control instruction is predicted taken. That branch is still part of the group.

The block owns the fetch address register, so the predicted successor of the last emitted slot becomes the fetch address of the next cycle. It also keeps two statistics counters. One counts taken predictions. The other is a histogram of group sizes.

Top module: `fetch_group_extractor`

## Requirements
- R1: `line_addr` equals `fetch_pc` with its low log2(LINE_BYTES) bits cleared. The first slot takes the word whose index is `fetch_pc[log2(LINE_BYTES)-1:2]`. Each further slot takes the next word of the same line. Line byte b is `line_data[8b+7:8b]`, so word k is `line_data[32k+31:32k]`, read little-endian.
- R2: When `line_valid` is high, `grp_count` is the smallest of three values: FETCH_W, the number of words from the start word to the line end, and the index of the first predicted-taken control slot plus one. When `line_valid` is low, `grp_count` is 0.
- R3: Slot 0 carries `fetch_pc` as its address, and each later slot carries the previous slot's address plus 4.
- R4: A word is a control instruction when bit CTRL_BIT (default 31) is 1. Lane i of `bp_query_valid` is high only for an emitted control slot, with `bp_query_pc` lane i set to that slot's address. A non-control slot's predicted successor is its address plus 4.
- R5: For an emitted control slot, the predicted successor is `bp_target` lane i when `bp_taken[i]` is 1, and otherwise the slot address plus 4. A taken slot is the last slot of the group.
- R6: Slot i carries `seq_next + i`. After a cycle with `line_valid` high, `seq_next` has advanced by the group count.
- R7: After a cycle with `line_valid` high, `fetch_pc` equals the predicted successor of the last emitted slot, and `next_pc` equals that value plus 4. After a cycle with `line_valid` low, `fetch_pc`, `next_pc` and `seq_next` hold their values.
- R8: `taken_total` rises by one in each cycle whose group ends on a predicted-taken control slot.
- R9: In each cycle with `line_valid` high, histogram bucket `grp_count` rises by one. Bucket k is `size_hist[k*STAT_W +: STAT_W]`, for k from 0 to FETCH_W.
- R10: Every lane of `grp_insn`, `grp_pc`, `grp_npc`, `grp_seq` and `bp_query_pc` that belongs to a slot at or beyond `grp_count` is 0.
- R11: After reset:
  - `fetch_pc` is RESET_PC and `next_pc` is RESET_PC+4,
  - `seq_next` is 0,
  - `taken_total` and all histogram buckets are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | 1 | A fault-free line for `line_addr` is present |
| line_data | input | LINE_BYTES*8 | Cache line contents, byte 0 in the low bits |
| fetch_pc | output | PC_W | Current fetch address |
| next_pc | output | PC_W | Fetch address plus 4 |
| line_addr | output | PC_W | Line-aligned fetch address |
| bp_query_valid | output | FETCH_W | Per-slot predictor query strobe |
| bp_query_pc | output | FETCH_W*PC_W | Per-slot query address |
| bp_taken | input | FETCH_W | Per-slot taken answer |
| bp_target | input | FETCH_W*PC_W | Per-slot predicted target |
| grp_count | output | clog2(FETCH_W+1) | Number of valid slots |
| grp_insn | output | FETCH_W*32 | Slot instruction words |
| grp_pc | output | FETCH_W*PC_W | Slot addresses |
| grp_npc | output | FETCH_W*PC_W | Slot predicted successors |
| grp_seq | output | FETCH_W*SEQ_W | Slot sequence numbers |
| seq_next | output | SEQ_W | Next sequence number to assign |
| taken_total | output | STAT_W | Taken prediction counter |
| size_hist | output | (FETCH_W+1)*STAT_W | Group-size histogram buckets |

## Verification
The bench attacks a start word in the last slot of the line. A design with a wrong bound there would read wrapped words from the line start. It also covers a taken branch in slot 0 and in the middle of the group. A design that dropped the branch or kept going past it would show a wrong count and a wrong next fetch address. A control word predicted not taken must not end the group, or the count falls short. The bench also checks cycles with no valid line. Any leakage of sequence numbers, histogram samples or address changes in those cycles shows up as a drift against the bench model.

// File: rtl/fgx_pkg.sv
package fgx_pkg;
   localparam int INSN_W     = 32;
   localparam int INSN_BYTES = INSN_W / 8;
endpackage

// File: rtl/fgx_slot_chain.sv
module fgx_slot_chain
   import fgx_pkg::*;
#(
   parameter int PC_W       = 32,
   parameter int LINE_BYTES = 64,
   parameter int FETCH_W    = 4,
   parameter int SEQ_W      = 16,
   parameter int CTRL_BIT   = 31,
   localparam int SLOTS     = LINE_BYTES / INSN_BYTES,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int IDX_W     = $clog2(SLOTS),
   localparam int GCNT_W    = $clog2(FETCH_W + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        line_valid,
   input  logic [LINE_BYTES*8-1:0]     line_data,
   input  logic [PC_W-1:0]             pc,
   input  logic [SEQ_W-1:0]            seq_base,
   input  logic [FETCH_W-1:0]          bp_taken,
   input  logic [FETCH_W*PC_W-1:0]     bp_target,
   output logic [FETCH_W-1:0]          query_valid,
   output logic [FETCH_W*PC_W-1:0]     query_pc,
   output logic [FETCH_W-1:0]          slot_valid,
   output logic [FETCH_W*INSN_W-1:0]   slot_insn,
   output logic [FETCH_W*PC_W-1:0]     slot_pc,
   output logic [FETCH_W*PC_W-1:0]     slot_npc,
   output logic [FETCH_W*SEQ_W-1:0]    slot_seq,
   output logic [GCNT_W-1:0]           count,
   output logic [PC_W-1:0]             final_npc,
   output logic                        taken_hit
);
   logic [IDX_W-1:0]  start_idx;
   logic [FETCH_W:0]  alive;
   logic [FETCH_W-1:0] take;
   logic [PC_W-1:0]   npc_a [FETCH_W];

   assign start_idx = pc[OFF_W-1:2];
   assign alive[0]  = line_valid;

   for (genvar g = 0; g < FETCH_W; g++) begin : g_slot
      logic [IDX_W-1:0]  word_idx;
      logic [INSN_W-1:0] word;
      logic [PC_W-1:0]   this_pc;
      logic [PC_W-1:0]   seq_pc;
      logic              in_line;
      logic              act;
      logic              is_ctrl;

      assign word_idx = start_idx + IDX_W'(g);
      assign in_line  = (int'(start_idx) + g) < SLOTS;
      assign word     = line_data[word_idx*INSN_W +: INSN_W];
      assign is_ctrl  = word[CTRL_BIT];
      assign act      = alive[g] & in_line;
      assign this_pc  = pc + PC_W'(INSN_BYTES * g);
      assign seq_pc   = this_pc + PC_W'(INSN_BYTES);
      assign take[g]  = act & is_ctrl & bp_taken[g];
      assign npc_a[g] = take[g] ? bp_target[g*PC_W +: PC_W] : seq_pc;
      assign alive[g+1] = act & ~take[g];

      assign slot_valid[g]                  = act;
      assign query_valid[g]                 = act & is_ctrl;
      assign query_pc[g*PC_W +: PC_W]       = (act & is_ctrl) ? this_pc : '0;
      assign slot_insn[g*INSN_W +: INSN_W]  = act ? word : '0;
      assign slot_pc[g*PC_W +: PC_W]        = act ? this_pc : '0;
      assign slot_npc[g*PC_W +: PC_W]       = act ? npc_a[g] : '0;
      assign slot_seq[g*SEQ_W +: SEQ_W]     = act ? seq_base + SEQ_W'(g) : '0;
   end

   always_comb begin
      final_npc = pc;
      for (int i = 0; i < FETCH_W; i++)
         if (slot_valid[i]) final_npc = npc_a[i];
   end

   assign count     = GCNT_W'($countones(slot_valid));
   assign taken_hit = |take;

   // R2: emitted slots form a contiguous run from slot 0
   a_r2_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      ((slot_valid + FETCH_W'(1)) & slot_valid) == '0);
   // R2: no group without a valid line
   a_r2_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !line_valid |-> (slot_valid == '0));
   // R4: queries only for emitted slots
   a_r4_query_subset: assert property (@(posedge clk) disable iff (!rst_n)
      (query_valid & ~slot_valid) == '0);
   // R5: a taken slot is the last one emitted
   a_r5_single_taken: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take));
endmodule

// File: rtl/fgx_stats.sv
module fgx_stats #(
   parameter int FETCH_W = 4,
   parameter int STAT_W  = 16,
   parameter bit HIST_EN = 1'b1,
   localparam int GCNT_W = $clog2(FETCH_W + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sample,
   input  logic [GCNT_W-1:0]             count,
   input  logic                          taken_hit,
   output logic [STAT_W-1:0]             taken_total,
   output logic [(FETCH_W+1)*STAT_W-1:0] size_hist
);
   always_ff @(posedge clk) begin
      if (!rst_n)         taken_total <= '0;
      else if (taken_hit) taken_total <= taken_total + STAT_W'(1);
   end

   if (HIST_EN) begin : g_hist
      for (genvar k = 0; k <= FETCH_W; k++) begin : g_bucket
         logic [STAT_W-1:0] bucket;
         always_ff @(posedge clk) begin
            if (!rst_n)
               bucket <= '0;
            else if (sample && (int'(count) == k))
               bucket <= bucket + STAT_W'(1);
         end
         assign size_hist[k*STAT_W +: STAT_W] = bucket;
      end
   end else begin : g_no_hist
      assign size_hist = '0;
   end

   // R8: the taken counter moves by exactly one per taken group
   a_r8_taken_step: assert property (@(posedge clk) disable iff (!rst_n)
      taken_hit |=> taken_total == $past(taken_total) + STAT_W'(1));
   a_r8_taken_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !taken_hit |=> $stable(taken_total));
endmodule

// File: rtl/fetch_group_extractor.sv
module fetch_group_extractor
   import fgx_pkg::*;
#(
   parameter int          PC_W       = 32,
   parameter int          LINE_BYTES = 64,
   parameter int          FETCH_W    = 4,
   parameter int          SEQ_W      = 16,
   parameter int          STAT_W     = 16,
   parameter int          CTRL_BIT   = 31,
   parameter bit          HIST_EN    = 1'b1,
   parameter logic [31:0] RESET_PC   = 32'h0000_1000,
   localparam int         OFF_W      = $clog2(LINE_BYTES),
   localparam int         GCNT_W     = $clog2(FETCH_W + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          line_valid,
   input  logic [LINE_BYTES*8-1:0]       line_data,
   output logic [PC_W-1:0]               fetch_pc,
   output logic [PC_W-1:0]               next_pc,
   output logic [PC_W-1:0]               line_addr,
   output logic [FETCH_W-1:0]            bp_query_valid,
   output logic [FETCH_W*PC_W-1:0]       bp_query_pc,
   input  logic [FETCH_W-1:0]            bp_taken,
   input  logic [FETCH_W*PC_W-1:0]       bp_target,
   output logic [GCNT_W-1:0]             grp_count,
   output logic [FETCH_W*INSN_W-1:0]     grp_insn,
   output logic [FETCH_W*PC_W-1:0]       grp_pc,
   output logic [FETCH_W*PC_W-1:0]       grp_npc,
   output logic [FETCH_W*SEQ_W-1:0]      grp_seq,
   output logic [SEQ_W-1:0]              seq_next,
   output logic [STAT_W-1:0]             taken_total,
   output logic [(FETCH_W+1)*STAT_W-1:0] size_hist
);
   if (LINE_BYTES < 8 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 8");
   end
   if (FETCH_W < 1) begin : g_bad_width
      $error("FETCH_W must be at least 1");
   end
   if (CTRL_BIT < 0 || CTRL_BIT >= INSN_W) begin : g_bad_ctrl
      $error("CTRL_BIT must select a bit of the instruction word");
   end
   if (PC_W <= OFF_W) begin : g_bad_pc
      $error("PC_W must exceed the line offset width");
   end

   logic [PC_W-1:0]     pc_q, npc_q;
   logic [SEQ_W-1:0]    seq_q;
   logic [FETCH_W-1:0]  slot_valid;
   logic [PC_W-1:0]     final_npc;
   logic                taken_hit;

   fgx_slot_chain #(
      .PC_W(PC_W), .LINE_BYTES(LINE_BYTES), .FETCH_W(FETCH_W),
      .SEQ_W(SEQ_W), .CTRL_BIT(CTRL_BIT)
   ) u_chain (
      .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_data(line_data),
      .pc(pc_q), .seq_base(seq_q), .bp_taken(bp_taken), .bp_target(bp_target),
      .query_valid(bp_query_valid), .query_pc(bp_query_pc),
      .slot_valid(slot_valid), .slot_insn(grp_insn), .slot_pc(grp_pc),
      .slot_npc(grp_npc), .slot_seq(grp_seq), .count(grp_count),
      .final_npc(final_npc), .taken_hit(taken_hit)
   );

   fgx_stats #(
      .FETCH_W(FETCH_W), .STAT_W(STAT_W), .HIST_EN(HIST_EN)
   ) u_stats (
      .clk(clk), .rst_n(rst_n), .sample(line_valid), .count(grp_count),
      .taken_hit(taken_hit), .taken_total(taken_total), .size_hist(size_hist)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q  <= PC_W'(RESET_PC);
         npc_q <= PC_W'(RESET_PC) + PC_W'(INSN_BYTES);
         seq_q <= '0;
      end else if (line_valid) begin
         pc_q  <= final_npc;
         npc_q <= final_npc + PC_W'(INSN_BYTES);
         seq_q <= seq_q + SEQ_W'(grp_count);
      end
   end

   assign fetch_pc  = pc_q;
   assign next_pc   = npc_q;
   assign seq_next  = seq_q;
   assign line_addr = {pc_q[PC_W-1:OFF_W], {OFF_W{1'b0}}};

   // R7: idle cycles leave the fetch address untouched
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !line_valid |=> $stable(fetch_pc) && $stable(next_pc));
   // R7: the successor register always tracks the fetch address
   a_r7_pair: assert property (@(posedge clk) disable iff (!rst_n)
      next_pc == fetch_pc + PC_W'(INSN_BYTES));
   // R6: sequence numbers advance by the emitted count
   a_r6_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
      line_valid |=> seq_next == $past(seq_next) + SEQ_W'($past(grp_count)));
   // R2: the group never exceeds the fetch width
   a_r2_width: assert property (@(posedge clk) disable iff (!rst_n)
      int'(grp_count) <= FETCH_W);
endmodule

// File: tb/fetch_group_extractor_test.sv
module fetch_group_extractor_test;
   localparam int PC_W = 32, LB = 64, FW = 4, SEQ_W = 16, STAT_W = 16;
   localparam int SLOTS = LB / 4;
   localparam int GCNT_W = $clog2(FW + 1);
   localparam logic [31:0] RPC = 32'h0000_1000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_valid = 1'b0;
   logic [LB*8-1:0] line_data = '0;
   logic [FW-1:0] bp_taken = '0;
   logic [FW*PC_W-1:0] bp_target = '0;
   logic [PC_W-1:0] fetch_pc, next_pc, line_addr;
   logic [FW-1:0] bp_query_valid;
   logic [FW*PC_W-1:0] bp_query_pc, grp_pc, grp_npc;
   logic [GCNT_W-1:0] grp_count;
   logic [FW*32-1:0] grp_insn;
   logic [FW*SEQ_W-1:0] grp_seq;
   logic [SEQ_W-1:0] seq_next;
   logic [STAT_W-1:0] taken_total;
   logic [(FW+1)*STAT_W-1:0] size_hist;

   always #2 clk = ~clk;

   fetch_group_extractor uut (
      .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_data(line_data),
      .fetch_pc(fetch_pc), .next_pc(next_pc), .line_addr(line_addr),
      .bp_query_valid(bp_query_valid), .bp_query_pc(bp_query_pc),
      .bp_taken(bp_taken), .bp_target(bp_target), .grp_count(grp_count),
      .grp_insn(grp_insn), .grp_pc(grp_pc), .grp_npc(grp_npc), .grp_seq(grp_seq),
      .seq_next(seq_next), .taken_total(taken_total), .size_hist(size_hist)
   );

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [PC_W-1:0] m_pc;
   logic [SEQ_W-1:0] m_seq;
   logic [STAT_W-1:0] m_taken;
   logic [STAT_W-1:0] m_hist [FW+1];
   int last_count;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_state();
      chk(fetch_pc == m_pc, "R7 fetch_pc", 64'(fetch_pc), 64'(m_pc));
      chk(next_pc == m_pc + 4, "R7 next_pc", 64'(next_pc), 64'(m_pc + 4));
      chk(line_addr == (m_pc & ~32'(LB - 1)), "R1 line_addr", 64'(line_addr),
          64'(m_pc & ~32'(LB - 1)));
      chk(seq_next == m_seq, "R6 seq_next", 64'(seq_next), 64'(m_seq));
      chk(taken_total == m_taken, "R8 taken_total", 64'(taken_total), 64'(m_taken));
      for (int k = 0; k <= FW; k++)
         chk(size_hist[k*STAT_W +: STAT_W] == m_hist[k], "R9 histogram bucket",
             64'(size_hist[k*STAT_W +: STAT_W]), 64'(m_hist[k]));
   endtask

   task automatic step(input bit v, input logic [LB*8-1:0] line,
                       input logic [FW-1:0] tk, input logic [FW*PC_W-1:0] tg);
      int start, n;
      bit alive;
      logic [PC_W-1:0] last;
      @(negedge clk);
      check_state();
      line_valid = v; line_data = line; bp_taken = tk; bp_target = tg;
      #1;
      start = int'(m_pc[5:2]);
      alive = v;
      n = 0;
      last = m_pc;
      for (int i = 0; i < FW; i++) begin
         if (alive && (start + i) < SLOTS) begin
            logic [31:0] w;
            logic [PC_W-1:0] epc, enpc;
            bit ctrl, take;
            w = line[(start + i)*32 +: 32];
            ctrl = w[31];
            epc = m_pc + PC_W'(4 * i);
            take = ctrl && tk[i];
            enpc = take ? tg[i*PC_W +: PC_W] : epc + 4;
            chk(grp_insn[i*32 +: 32] == w, "R1 slot word", 64'(grp_insn[i*32 +: 32]), 64'(w));
            chk(grp_pc[i*PC_W +: PC_W] == epc, "R3 slot pc", 64'(grp_pc[i*PC_W +: PC_W]), 64'(epc));
            chk(grp_npc[i*PC_W +: PC_W] == enpc, "R5 slot npc", 64'(grp_npc[i*PC_W +: PC_W]), 64'(enpc));
            chk(grp_seq[i*SEQ_W +: SEQ_W] == m_seq + SEQ_W'(i), "R6 slot seq",
                64'(grp_seq[i*SEQ_W +: SEQ_W]), 64'(m_seq + SEQ_W'(i)));
            chk(bp_query_valid[i] == ctrl, "R4 query strobe", 64'(bp_query_valid[i]), 64'(ctrl));
            chk(bp_query_pc[i*PC_W +: PC_W] == (ctrl ? epc : '0), "R4 query pc",
                64'(bp_query_pc[i*PC_W +: PC_W]), 64'(ctrl ? epc : '0));
            n++;
            last = enpc;
            if (take) begin alive = 0; m_taken++; end
         end else begin
            alive = 0;
            chk(grp_insn[i*32 +: 32] == '0 && grp_pc[i*PC_W +: PC_W] == '0 &&
                grp_npc[i*PC_W +: PC_W] == '0 && grp_seq[i*SEQ_W +: SEQ_W] == '0 &&
                bp_query_pc[i*PC_W +: PC_W] == '0 && !bp_query_valid[i],
                "R10 idle slot zero", 64'(grp_pc[i*PC_W +: PC_W]), 64'(0));
         end
      end
      chk(int'(grp_count) == n, "R2 group count", 64'(grp_count), 64'(n));
      last_count = n;
      if (v) begin
         m_pc = last;
         m_seq = m_seq + SEQ_W'(n);
         m_hist[n]++;
      end
   endtask

   function automatic logic [LB*8-1:0] plain_line(input int seed);
      logic [LB*8-1:0] l;
      for (int k = 0; k < SLOTS; k++) l[k*32 +: 32] = {1'b0, 31'(seed * 977 + k * 131)};
      return l;
   endfunction

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [LB*8-1:0] l;
      logic [FW*PC_W-1:0] t;
      void'($urandom(32'd20240611));
      m_pc = RPC; m_seq = '0; m_taken = '0;
      for (int k = 0; k <= FW; k++) m_hist[k] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state
      @(negedge clk);
      chk(fetch_pc == RPC && next_pc == RPC + 4 && seq_next == 0 && taken_total == 0
          && size_hist == '0, "R11 reset state", 64'(fetch_pc), 64'(RPC));

      // R2 width limit: line start, no control words
      step(1, plain_line(1), '0, '0);
      chk(last_count == FW, "R2 width limit", 64'(last_count), 64'(FW));

      // R5 taken in slot 0 jumps to the last word of a line
      l = plain_line(2);
      l[(int'(m_pc[5:2]))*32 + 31] = 1'b1;
      t = '0; t[0 +: PC_W] = 32'h0000_203C;
      step(1, l, 4'b0001, t);
      chk(last_count == 1, "R5 taken slot0 ends group", 64'(last_count), 64'(1));
      // R2 line end: starting at the final word gives one slot
      step(1, plain_line(3), '0, '0);
      chk(last_count == 1, "R2 line end", 64'(last_count), 64'(1));
      chk(m_pc == 32'h0000_2040, "R7 line wrap address", 64'(m_pc), 64'h2040);

      // R5 control predicted not taken does not end the group
      l = plain_line(4);
      l[(int'(m_pc[5:2]) + 1)*32 + 31] = 1'b1;
      step(1, l, 4'b0000, '1);
      chk(last_count == FW, "R5 not-taken keeps going", 64'(last_count), 64'(FW));

      // R5 taken in slot 2 keeps the branch, count three
      l = plain_line(5);
      l[(int'(m_pc[5:2]) + 2)*32 + 31] = 1'b1;
      t = '0; t[2*PC_W +: PC_W] = 32'h0000_3038;
      step(1, l, 4'b0100, t);
      chk(last_count == 3, "R5 mid-group taken", 64'(last_count), 64'(3));

      // R7 idle cycle holds everything
      step(0, plain_line(6), '1, '1);
      chk(last_count == 0, "R2 idle count", 64'(last_count), 64'(0));

      // random phase
      for (int c = 0; c < 3000; c++) begin
         logic [FW-1:0] tk;
         for (int k = 0; k < SLOTS; k++) begin
            l[k*32 +: 32] = $urandom;
            l[k*32 + 31] = ($urandom % 4) == 0;
         end
         for (int i = 0; i < FW; i++)
            t[i*PC_W +: PC_W] = 32'h0000_4000 | (($urandom % 1024) << 2);
         tk = FW'($urandom);
         step(($urandom % 5) != 0, l, tk, t);
      end
      @(negedge clk);
      check_state();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule